// File: doc/BRIEF.md
# JTAG debug port access logic

This block is the target-side register logic of a JTAG debug port. A standard TAP controller, outside the block, supplies the current instruction and the capture, shift and update strobes of the data-register path. The block chooses a data register from the instruction, shifts it between `tdi` and `tdo`, and acts on the scanned value when update arrives. For debug-port and access-port accesses it uses a 35-bit scan register. It holds the debug-port registers: control/status with sticky flags and power-up handshake bits, bank select, and read buffer. Access-port transfers go out over a request/acknowledge bus.

Reads are posted. A scan only launches an operation. The data captured at the next scan of the access register is the result of the previous read. While an access-port transfer is still in flight, an access scan captures a WAIT acknowledge, and the operation scanned in is dropped. If overrun detection is on, a sticky overrun flag is set. An abort scan ends a stuck transfer.

The access-port sequencer is a two-state machine. It starts in AP_IDLE. It moves from AP_IDLE to AP_BUSY when an accepted access-port update launches a request. It moves from AP_BUSY back to AP_IDLE when the acknowledge arrives or when an abort with data bit 0 set is updated. `ap_req` is high exactly in AP_BUSY.

Top module: `jdp_access`

## Requirements
- R1: Instruction 0xF8 selects the abort register, 0xFA the debug-port access register, 0xFB the access-port access register and 0xFE the identification register. Every other instruction value selects a 1-bit bypass register that captures 0 and delays `tdi` by one shift.
- R2: With the identification instruction, capture loads the 32-bit parameter `IDCODE_VAL`, which shifts out least significant bit first over 32 shifts.
- R3: The access scan register is 35 bits, shifted least significant bit first. Bit 0 is read-not-write (1 = read). Bits 2:1 are register address A[3:2]. Bits 34:3 are the 32-bit data.
- R4: When no access-port transfer is pending, an access scan captures the acknowledge 3'b010 (OK) in bits 2:1:0.
- R5: The data captured by an access scan is the result of the most recent completed read. A debug-port read updates it at its own update. An access-port read updates it when its acknowledge arrives.
- R6: An accepted access-port update raises `ap_req` with `ap_sel` = select[31:24], `ap_addr` = {select[7:4], A[3:2]}, `ap_write` = not read-not-write, and `ap_wdata` = the scanned data. These stay stable until the cycle of `ap_ack`, after which `ap_req` drops.
- R7: An access scan captured while a transfer is pending returns the acknowledge 3'b001 (WAIT). Its update is discarded. If control/status bit 0 (overrun detect) is 1, sticky overrun (control/status bit 1) is set.
- R8: The read buffer (address 3) returns the data of the last access-port read and has no side effect. A write to it is ignored.
- R9: An access-port update is discarded, with no request issued, while sticky overrun (bit 1) or sticky error (bit 5) is set.
- R10: Writing 1 to bit 1 or bit 5 of control/status clears that sticky bit. An acknowledge that arrives with `ap_err` high sets sticky error.
- R11: Bank select (address 2) reads back the value written. Control/status (address 1) is visible only when select[3:0] is 0. Otherwise, and at address 0, reads return 0.
- R12: An abort scan with data bit 0 = 1 ends a pending transfer, and `ap_req` is low right after that update. With data bit 0 = 0 it has no effect.
- R13: Control/status bits 28 and 30 are writable power-up requests driven on `dbg_pwr_req` and `sys_pwr_req`. Bits 29 and 31 read `pwr_ack[0]` and `pwr_ack[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_value | input | 8 | Current TAP instruction |
| capture_dr | input | 1 | Capture strobe of the data-register path |
| shift_dr | input | 1 | Shift strobe, one bit per cycle |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the selected register) |
| pwr_ack | input | 2 | Power-up acknowledges: [0] debug, [1] system |
| dbg_pwr_req | output | 1 | Debug power-up request |
| sys_pwr_req | output | 1 | System power-up request |
| ap_req | output | 1 | Access-port request, held until acknowledge |
| ap_write | output | 1 | Request is a write |
| ap_sel | output | 8 | Selected access port |
| ap_addr | output | 6 | Register bank and word address |
| ap_wdata | output | 32 | Write data |
| ap_ack | input | 1 | Transfer done, one-cycle pulse |
| ap_err | input | 1 | Transfer error, valid with `ap_ack` |
| ap_rdata | input | 32 | Read data, valid with `ap_ack` |

## Verification
A sequencer stuck in AP_BUSY shows up at the next access capture: bit 0 of `tdo` is 1 (WAIT) instead of 0. A lost request shows up as a missing `ap_req` within one cycle of update. A wrong posted result or read buffer shows up in the data bits of the scan that follows the read. A sticky flag that fails to set or clear shows up in the control/status value read two scans later. It also shows up as a request that appears or is missing on the access-port bus after the next access-port update.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
    localparam int IR_W   = 8;
    localparam int HDR_W  = 3;
    localparam int WORD_W = 32;
    localparam int SCAN_W = HDR_W + WORD_W;
    localparam int SEL_W  = 8;
    localparam int BANK_W = 4;
    localparam int APA_W  = BANK_W + 2;

    localparam logic [IR_W-1:0] IR_ABORT  = 8'hF8;
    localparam logic [IR_W-1:0] IR_DPACC  = 8'hFA;
    localparam logic [IR_W-1:0] IR_APACC  = 8'hFB;
    localparam logic [IR_W-1:0] IR_IDCODE = 8'hFE;

    localparam logic [HDR_W-1:0] ACK_WAIT = 3'b001;
    localparam logic [HDR_W-1:0] ACK_OK   = 3'b010;

    localparam int CS_ORUNDET = 0;
    localparam int CS_STKORUN = 1;
    localparam int CS_STKERR  = 5;
    localparam int CS_DBGREQ  = 28;
    localparam int CS_DBGACK  = 29;
    localparam int CS_SYSREQ  = 30;
    localparam int CS_SYSACK  = 31;

    localparam logic [1:0] DPA_CTRL  = 2'd1;
    localparam logic [1:0] DPA_SEL   = 2'd2;
    localparam logic [1:0] DPA_RDBUF = 2'd3;

    typedef enum logic [2:0] {
        SEL_BYPASS, SEL_ABORT, SEL_DPACC, SEL_APACC, SEL_IDCODE
    } dr_sel_e;

    typedef enum logic {AP_IDLE, AP_BUSY} ap_state_e;
endpackage

// File: rtl/jdp_ir_decode.sv
module jdp_ir_decode
    import jdp_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output dr_sel_e         dsel
);
    always_comb begin
        unique case (ir)
            IR_ABORT:  dsel = SEL_ABORT;
            IR_DPACC:  dsel = SEL_DPACC;
            IR_APACC:  dsel = SEL_APACC;
            IR_IDCODE: dsel = SEL_IDCODE;
            default:   dsel = SEL_BYPASS;
        endcase
    end
endmodule

// File: rtl/jdp_ap_fsm.sv
module jdp_ap_fsm
    import jdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              abort,
    input  logic              rnw_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [APA_W-1:0]  addr_in,
    input  logic [WORD_W-1:0] wdata_in,
    input  logic              ap_ack,
    output logic              busy,
    output logic              ap_req,
    output logic              ap_write,
    output logic [SEL_W-1:0]  ap_sel,
    output logic [APA_W-1:0]  ap_addr,
    output logic [WORD_W-1:0] ap_wdata,
    output logic              done,
    output logic              rd_done
);
    ap_state_e state, state_nx;
    logic      rnw_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            AP_IDLE: if (launch)          state_nx = AP_BUSY;
            AP_BUSY: if (abort || ap_ack) state_nx = AP_IDLE;
            default:                      state_nx = AP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= AP_IDLE;
            rnw_q    <= 1'b0;
            ap_sel   <= '0;
            ap_addr  <= '0;
            ap_wdata <= '0;
        end else begin
            state <= state_nx;
            if (state == AP_IDLE && launch) begin
                rnw_q    <= rnw_in;
                ap_sel   <= sel_in;
                ap_addr  <= addr_in;
                ap_wdata <= wdata_in;
            end
        end
    end

    always_comb begin
        busy     = (state == AP_BUSY);
        ap_req   = busy;
        ap_write = !rnw_q;
        done     = busy && ap_ack && !abort;
        rd_done  = done && rnw_q;
    end
endmodule

// File: rtl/jdp_dp_regs.sv
module jdp_dp_regs
    import jdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_wr,
    input  logic              dp_rd,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              ap_done,
    input  logic              ap_rd_done,
    input  logic              ap_err,
    input  logic [WORD_W-1:0] ap_rdata,
    input  logic              ovr_try,
    input  logic [1:0]        pwr_ack,
    output logic [WORD_W-1:0] select_q,
    output logic [WORD_W-1:0] result_q,
    output logic              sticky_any,
    output logic              dbg_req,
    output logic              sys_req
);
    logic              orundet, stk_orun, stk_err;
    logic [WORD_W-1:0] rdbuf_q, rd_val;
    logic              ctrl_vis;

    assign ctrl_vis   = (select_q[BANK_W-1:0] == '0);
    assign sticky_any = stk_orun || stk_err;

    always_comb begin
        rd_val = '0;
        unique case (addr)
            DPA_CTRL: if (ctrl_vis) begin
                rd_val[CS_ORUNDET] = orundet;
                rd_val[CS_STKORUN] = stk_orun;
                rd_val[CS_STKERR]  = stk_err;
                rd_val[CS_DBGREQ]  = dbg_req;
                rd_val[CS_DBGACK]  = pwr_ack[0];
                rd_val[CS_SYSREQ]  = sys_req;
                rd_val[CS_SYSACK]  = pwr_ack[1];
            end
            DPA_SEL:   rd_val = select_q;
            DPA_RDBUF: rd_val = rdbuf_q;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            orundet  <= 1'b0;
            stk_orun <= 1'b0;
            stk_err  <= 1'b0;
            dbg_req  <= 1'b0;
            sys_req  <= 1'b0;
            select_q <= '0;
            rdbuf_q  <= '0;
            result_q <= '0;
        end else begin
            if (ovr_try && orundet)
                stk_orun <= 1'b1;
            else if (dp_wr && addr == DPA_CTRL && ctrl_vis && wdata[CS_STKORUN])
                stk_orun <= 1'b0;
            if (ap_done && ap_err)
                stk_err <= 1'b1;
            else if (dp_wr && addr == DPA_CTRL && ctrl_vis && wdata[CS_STKERR])
                stk_err <= 1'b0;
            if (dp_wr && addr == DPA_CTRL && ctrl_vis) begin
                orundet <= wdata[CS_ORUNDET];
                dbg_req <= wdata[CS_DBGREQ];
                sys_req <= wdata[CS_SYSREQ];
            end
            if (dp_wr && addr == DPA_SEL)
                select_q <= wdata;
            if (ap_rd_done) begin
                rdbuf_q  <= ap_rdata;
                result_q <= ap_rdata;
            end else if (dp_rd) begin
                result_q <= rd_val;
            end
        end
    end
endmodule

// File: rtl/jdp_access.sv
module jdp_access
    import jdp_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h1234_5679
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IR_W-1:0]   ir_value,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [1:0]        pwr_ack,
    output logic              dbg_pwr_req,
    output logic              sys_pwr_req,
    output logic              ap_req,
    output logic              ap_write,
    output logic [SEL_W-1:0]  ap_sel,
    output logic [APA_W-1:0]  ap_addr,
    output logic [WORD_W-1:0] ap_wdata,
    input  logic              ap_ack,
    input  logic              ap_err,
    input  logic [WORD_W-1:0] ap_rdata
);
    dr_sel_e           dsel;
    logic [SCAN_W-1:0] sr_q, sr_nx;
    logic              wait_q, acc_sel, upd_ok;
    logic              dp_wr, dp_rd, launch, abort_go, ovr_try;
    logic              busy, ap_done, ap_rd_done, sticky_any;
    logic [WORD_W-1:0] select_q, result_q;

    jdp_ir_decode u_dec (.ir(ir_value), .dsel(dsel));

    assign acc_sel  = (dsel == SEL_DPACC) || (dsel == SEL_APACC);
    assign upd_ok   = update_dr && !wait_q;
    assign dp_wr    = upd_ok && dsel == SEL_DPACC && !sr_q[0];
    assign dp_rd    = upd_ok && dsel == SEL_DPACC && sr_q[0];
    assign launch   = upd_ok && dsel == SEL_APACC && !sticky_any;
    assign abort_go = update_dr && dsel == SEL_ABORT && sr_q[HDR_W];
    assign ovr_try  = update_dr && acc_sel && wait_q;
    assign tdo      = sr_q[0];

    always_comb begin
        sr_nx = sr_q;
        if (capture_dr) begin
            unique case (dsel)
                SEL_IDCODE: sr_nx = {{HDR_W{1'b0}}, IDCODE_VAL};
                SEL_BYPASS: sr_nx = '0;
                default:    sr_nx = {result_q, busy ? ACK_WAIT : ACK_OK};
            endcase
        end else if (shift_dr) begin
            sr_nx = sr_q >> 1;
            unique case (dsel)
                SEL_IDCODE: sr_nx[WORD_W-1] = tdi;
                SEL_BYPASS: sr_nx[0]        = tdi;
                default:    sr_nx[SCAN_W-1] = tdi;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            wait_q <= 1'b0;
        end else begin
            sr_q <= sr_nx;
            if (capture_dr)
                wait_q <= acc_sel && busy;
        end
    end

    jdp_ap_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .launch(launch), .abort(abort_go),
        .rnw_in(sr_q[0]), .sel_in(select_q[WORD_W-1 -: SEL_W]),
        .addr_in({select_q[2*BANK_W-1:BANK_W], sr_q[2:1]}),
        .wdata_in(sr_q[SCAN_W-1:HDR_W]), .ap_ack(ap_ack), .busy(busy),
        .ap_req(ap_req), .ap_write(ap_write), .ap_sel(ap_sel),
        .ap_addr(ap_addr), .ap_wdata(ap_wdata), .done(ap_done),
        .rd_done(ap_rd_done)
    );

    jdp_dp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .dp_wr(dp_wr), .dp_rd(dp_rd),
        .addr(sr_q[2:1]), .wdata(sr_q[SCAN_W-1:HDR_W]), .ap_done(ap_done),
        .ap_rd_done(ap_rd_done), .ap_err(ap_err), .ap_rdata(ap_rdata),
        .ovr_try(ovr_try), .pwr_ack(pwr_ack), .select_q(select_q),
        .result_q(result_q), .sticky_any(sticky_any),
        .dbg_req(dbg_pwr_req), .sys_req(sys_pwr_req)
    );
endmodule

// File: rtl/jdp_access_chk.sv
module jdp_access_chk
    import jdp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              capture_dr,
    input logic              update_dr,
    input logic              acc_sel,
    input logic              wait_q,
    input logic              abort_go,
    input logic              tdo,
    input logic              ap_req,
    input logic              ap_ack,
    input logic [SEL_W-1:0]  ap_sel,
    input logic [APA_W-1:0]  ap_addr,
    input logic [WORD_W-1:0] ap_wdata
);
    p_ok_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr && acc_sel && !ap_req |=> !tdo);

    p_wait_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capture_dr && acc_sel && ap_req |=> tdo);

    p_wait_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        update_dr && acc_sel && wait_q |=> !$rose(ap_req));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req && !ap_ack && !abort_go |=>
            ap_req && $stable(ap_sel) && $stable(ap_addr) && $stable(ap_wdata));

    p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ap_req && ap_ack |=> !ap_req);

    p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        abort_go |=> !ap_req);
endmodule

bind jdp_access jdp_access_chk u_chk (
    .clk(clk), .rst_n(rst_n), .capture_dr(capture_dr), .update_dr(update_dr),
    .acc_sel(acc_sel), .wait_q(wait_q), .abort_go(abort_go), .tdo(tdo),
    .ap_req(ap_req), .ap_ack(ap_ack), .ap_sel(ap_sel), .ap_addr(ap_addr),
    .ap_wdata(ap_wdata)
);

// File: tb/jdp_access_test.sv
module jdp_access_test;
    localparam logic [31:0] IDV = 32'h5EED_C0DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ir_value = 8'hFA;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic [1:0]  pwr_ack = 2'b00;
    logic        dbg_pwr_req, sys_pwr_req;
    logic        ap_req, ap_write;
    logic [7:0]  ap_sel;
    logic [5:0]  ap_addr;
    logic [31:0] ap_wdata;
    logic        ap_ack, ap_err;
    logic [31:0] ap_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    jdp_access #(.IDCODE_VAL(IDV)) uut (
        .clk(clk), .rst_n(rst_n), .ir_value(ir_value), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .pwr_ack(pwr_ack), .dbg_pwr_req(dbg_pwr_req), .sys_pwr_req(sys_pwr_req),
        .ap_req(ap_req), .ap_write(ap_write), .ap_sel(ap_sel), .ap_addr(ap_addr),
        .ap_wdata(ap_wdata), .ap_ack(ap_ack), .ap_err(ap_err), .ap_rdata(ap_rdata)
    );

    // Access-port model with adjustable latency
    logic [31:0] apmem [0:63];
    int          ap_lat = 2;
    int          cnt = 0;
    int          req_cnt = 0;
    logic        err_next = 1'b0;
    logic [7:0]  last_sel;
    logic [5:0]  last_addr;
    logic        last_wr;
    logic [31:0] last_wd;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) apmem[i] <= '0;
            ap_ack <= 1'b0; ap_err <= 1'b0; ap_rdata <= '0; cnt <= 0;
        end else begin
            ap_ack <= 1'b0;
            ap_err <= 1'b0;
            if (ap_req && !ap_ack) begin
                if (cnt == 0) begin
                    req_cnt   <= req_cnt + 1;
                    last_sel  <= ap_sel;
                    last_addr <= ap_addr;
                    last_wr   <= ap_write;
                    last_wd   <= ap_wdata;
                end
                if (cnt >= ap_lat) begin
                    ap_ack   <= 1'b1;
                    ap_err   <= err_next;
                    cnt      <= 0;
                    ap_rdata <= apmem[ap_addr] ^ {ap_sel, 24'h0};
                    if (ap_write) apmem[ap_addr] <= ap_wdata;
                end else begin
                    cnt <= cnt + 1;
                end
            end else if (!ap_req) begin
                cnt <= 0;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic scan(input int len, input logic [34:0] din, output logic [34:0] dout);
        dout = '0;
        @(negedge clk) capture_dr = 1'b1;
        @(negedge clk) capture_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            @(negedge clk);
        end
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge clk) update_dr = 1'b0;
    endtask

    task automatic acc(input logic ap, input logic [1:0] a, input logic rnw,
                       input logic [31:0] d, output logic [2:0] ack, output logic [31:0] q);
        logic [34:0] o;
        ir_value = ap ? 8'hFB : 8'hFA;
        scan(35, {d, a, rnw}, o);
        ack = o[2:0];
        q   = o[34:3];
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0]  ack;
        logic [31:0] q, v, sv, cur_sel;
        logic [34:0] o;
        logic [7:0]  sel;
        int          rc;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // Reset state and posted reads (R4, R5)
        acc(0, 1, 1, 0, ack, q);
        chk("R4 ack after reset", ack, 3'b010);
        chk("R5 data after reset", q, 0);
        acc(0, 2, 1, 0, ack, q);
        chk("R5 ctrl reset value", q, 0);

        // Identification register (R2)
        ir_value = 8'hFE;
        scan(32, '0, o);
        chk("R2 idcode", o[31:0], IDV);

        // Bypass sweep over every undecoded instruction (R1)
        for (int ir = 0; ir < 256; ir++) begin
            if (ir != 8'hF8 && ir != 8'hFA && ir != 8'hFB && ir != 8'hFE) begin
                ir_value = ir[7:0];
                scan(2, 35'b01, o);
                chk("R1 bypass", {ir[7:0], o[1:0]}, {ir[7:0], 2'b10});
            end
        end

        // Control visibility by bank and select readback (R11)
        acc(0, 1, 0, 32'h0000_0001, ack, q);
        acc(0, 2, 0, 32'hDEAD_00F1, ack, q);
        acc(0, 1, 1, 0, ack, q);
        acc(0, 2, 1, 0, ack, q);
        chk("R11 ctrl hidden in bank 1", q, 0);
        acc(0, 0, 1, 0, ack, q);
        chk("R11 select readback", q, 32'hDEAD_00F1);
        acc(0, 2, 0, 32'h0, ack, q);
        chk("R11 address 0 reads zero", q, 0);
        acc(0, 1, 1, 0, ack, q);
        acc(0, 3, 1, 0, ack, q);
        chk("R11 ctrl visible in bank 0", q, 32'h0000_0001);

        // Power-up requests and acknowledges (R13)
        pwr_ack = 2'b11;
        acc(0, 1, 0, 32'h5000_0001, ack, q);
        chk("R13 request outputs", {dbg_pwr_req, sys_pwr_req}, 2'b11);
        acc(0, 1, 1, 0, ack, q);
        acc(0, 3, 1, 0, ack, q);
        chk("R13 ctrl readback", q, 32'hF000_0001);

        // Sweep over banks and word addresses (R3, R5, R6, R8)
        for (int b = 0; b < 16; b++) begin
            for (int a = 0; a < 4; a++) begin
                sel = {b[3:0], ~b[3:0]};
                sv  = {sel, 16'h0, b[3:0], 4'h0};
                v   = 32'hA500_0000 ^ (b * 32'h0001_0100) ^ (a * 32'h0101_0101) ^ 32'h3C;
                acc(0, 2, 0, sv, ack, q);
                acc(1, a[1:0], 0, v, ack, q);
                chk("R4 ack on AP write", ack, 3'b010);
                idle(8);
                chk("R6 request fields", {last_sel, last_addr, last_wr, last_wd},
                    {sel, b[3:0], a[1:0], 1'b1, v});
                acc(1, a[1:0], 1, 0, ack, q);
                idle(8);
                chk("R3 read flag", last_wr, 1'b0);
                acc(0, 3, 1, 0, ack, q);
                chk("R5 posted AP read", q, v ^ {sel, 24'h0});
                acc(0, 3, 1, 0, ack, q);
                chk("R8 read buffer", q, v ^ {sel, 24'h0});
                cur_sel = sv;
            end
        end
        v = 32'h0F0F_5A5A ^ {8'hF0, 24'h0};
        acc(0, 2, 1, 0, ack, q);
        acc(0, 3, 0, 32'hFFFF_FFFF, ack, q);
        acc(0, 3, 1, 0, ack, q);
        chk("R5 select posted", q, cur_sel);
        acc(0, 0, 1, 0, ack, q);
        chk("R8 write ignored, no side effect", q, apmem[6'h3F] ^ {8'hF0, 24'h0} ^ {8'hF0, 24'h0} ^ {8'hF0, 24'h0});

        // WAIT and overrun (R7)
        acc(0, 2, 0, 32'h0, ack, q);
        cur_sel = 32'h0;
        ap_lat = 40;
        acc(1, 0, 0, 32'h1111_2222, ack, q);
        acc(0, 2, 0, 32'h1234_5678, ack, q);
        chk("R7 wait ack", ack, 3'b001);
        idle(60);
        acc(0, 2, 1, 0, ack, q);
        chk("R7 ok after completion", ack, 3'b010);
        acc(0, 1, 1, 0, ack, q);
        chk("R7 write discarded", q, cur_sel);
        acc(0, 3, 1, 0, ack, q);
        chk("R7 sticky overrun", q, 32'hF000_0003);

        // AP access discarded while sticky set (R9)
        ap_lat = 2;
        rc = req_cnt;
        acc(1, 0, 0, 32'h7777_7777, ack, q);
        idle(10);
        chk("R9 no request with overrun", req_cnt, rc);

        // W1C and error capture (R10)
        acc(0, 1, 0, 32'h5000_0003, ack, q);
        acc(0, 1, 1, 0, ack, q);
        acc(0, 3, 1, 0, ack, q);
        chk("R10 overrun cleared", q, 32'hF000_0001);
        err_next = 1'b1;
        acc(1, 1, 1, 0, ack, q);
        idle(8);
        err_next = 1'b0;
        acc(0, 1, 1, 0, ack, q);
        acc(0, 3, 1, 0, ack, q);
        chk("R10 sticky error set", q, 32'hF000_0021);
        rc = req_cnt;
        acc(1, 0, 0, 32'h1, ack, q);
        idle(8);
        chk("R9 no request with error", req_cnt, rc);
        acc(0, 1, 0, 32'h5000_0021, ack, q);
        acc(0, 1, 1, 0, ack, q);
        acc(0, 3, 1, 0, ack, q);
        chk("R10 error cleared", q, 32'hF000_0001);

        // Abort (R12)
        ap_lat = 1000;
        acc(1, 2, 1, 0, ack, q);
        idle(5);
        ir_value = 8'hF8;
        scan(35, {32'h0, 3'b000}, o);
        idle(3);
        chk("R12 abort with 0 no effect", ap_req, 1'b1);
        scan(35, {32'h1, 3'b000}, o);
        chk("R12 abort ends transfer", ap_req, 1'b0);
        acc(0, 1, 1, 0, ack, q);
        chk("R12 ok after abort", ack, 3'b010);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule